// File: doc/BRIEF.md
# Data-Edge Jitter Peak-to-Peak Meter

This block measures how far data transitions wander relative to a recovered bit clock. Each qualifying transition on the sampled data line opens an interval. A tick that runs at one hundred times the bit rate advances the interval. The next bit-clock strobe closes it. Because the clock strobe sits nominally in the middle of the bit, a count of 100 spans one full bit period, so every count reads directly in hundredths of a bit.

Over a test, the block keeps a floor value and a spread value. The spread is the reported peak-to-peak figure, in percent of a bit period. A mode input chooses between two kinds of measurement. In single-edge jitter mode only rising transitions open intervals. In total-peak mode both transitions open intervals, so any bias between marks and spaces adds to the result. Every completed count is also held on an output, together with a coarse level in steps of ten counts, for an external analog monitor. When the system runs from an external clock there is no 100x tick, and an input turns the meter off.

Top module: `jitter_pp_meter`

## Requirements
- R1: After reset, `spread`, `last_count` and `level` are all 0.
- R2: An interval opens in the cycle where a qualifying edge is seen. It closes in the cycle where `bit_stb` is high. Its count is the number of cycles strictly between those two cycles in which `tick` was high. `last_count` shows that count from the cycle after `bit_stb`.
- R3: A `start` pulse clears `spread` to 0 and arms the test. The first interval completed after that sets the floor to its count and leaves `spread` at 0.
- R4: A count below the floor replaces the floor and leaves `spread` unchanged.
- R5: A count above floor plus `spread` sets `spread` to that count minus the floor.
- R6: A count from the floor up to floor plus `spread`, inclusive, changes neither store.
- R7: With `mode_both` = 0, only a 0-to-1 transition of `data_in` qualifies. A 1-to-0 transition opens no interval.
- R8: With `mode_both` = 1, both 0-to-1 and 1-to-0 transitions of `data_in` qualify.
- R9: While `ext_clk_sel` = 1, no interval opens or completes, and all outputs hold their values.
- R10: An open interval whose count is already 100 and that sees one more tick before a strobe is dropped with no result. A count of exactly 100 is accepted.
- R11: `level` equals `last_count` divided by 10, rounded down.
- R12: A qualifying edge that arrives while an interval is open restarts that interval from zero.
- R13: Before the first `start`, completed intervals update `last_count` but leave `spread` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Sampled serial data |
| bit_stb | input | 1 | One-cycle strobe at each recovered bit-clock edge |
| tick | input | 1 | Enable at 100 times the bit rate |
| mode_both | input | 1 | 0: rising edges only (jitter); 1: both edges (total peak) |
| ext_clk_sel | input | 1 | 1 disables measurement (no tick exists) |
| start | input | 1 | One-cycle pulse that begins a test |
| spread | output | 7 | Peak-to-peak result in hundredths of a bit |
| last_count | output | 7 | Count of the latest completed interval |
| level | output | 4 | last_count in steps of 10 counts, for the monitor |

## Verification
The bench first feeds a rising-edge series that rises, stays inside the window, drops below the floor, and then rises again past the shifted window. This separates a floor-and-spread store from a plain minimum and maximum pair, because after the floor drops a count near the old maximum must still widen the spread. Falling transitions in jitter mode, alternating transitions in total-peak mode, and a zero-length interval show which edges qualify. Intervals of 100 and 101 ticks, an edge that arrives while an interval is open, and a burst with the external clock selected check the timeout, the restart and the disable paths at the outputs.

// File: rtl/jpp_pkg.sv
package jpp_pkg;
  // Saturating increment of an interval count.
  function automatic int sat_inc(int v, int vmax);
    return (v >= vmax) ? vmax : v + 1;
  endfunction

  // A count below the floor moves the floor.
  function automatic bit is_below(int v, int floor_v);
    return v < floor_v;
  endfunction

  // A count above the current window widens the spread.
  function automatic bit above_window(int v, int floor_v, int spr);
    return v > floor_v + spr;
  endfunction

  function automatic int new_spread(int v, int floor_v);
    return v - floor_v;
  endfunction

  // Coarse monitor level: one step per STEP counts.
  function automatic int level_of(int v, int step);
    return v / step;
  endfunction
endpackage

// File: rtl/jpp_edge_qual.sv
module jpp_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic data_in,
  input  logic both_edges,
  output logic qual
);
  logic prev_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= data_in;
  end

  assign rise_w = data_in & ~prev_q;
  assign fall_w = ~data_in & prev_q;
  assign qual   = enable & (both_edges ? (rise_w | fall_w) : rise_w);

  // R7: in jitter mode an interval only opens while data is high
  a_r7_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_edges && qual) |-> data_in);
endmodule

// File: rtl/jpp_interval_timer.sv
module jpp_interval_timer #(
  parameter int CNT_MAX   = 127,
  parameter int BIT_TICKS = 100,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          qual,
  input  logic          bit_stb,
  input  logic          tick,
  output logic          done,
  output logic [CW-1:0] done_val,
  output logic          running
);
  import jpp_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          timeout_w;

  assign done      = enable & run_q & bit_stb;
  assign done_val  = cnt_q;
  assign running   = run_q;
  assign timeout_w = run_q & tick & ~bit_stb & (int'(cnt_q) >= BIT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (qual) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && bit_stb) begin
      run_q <= 1'b0;
    end else if (timeout_w) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= CW'(sat_inc(int'(cnt_q), CNT_MAX));
    end
  end

  // R10: an open interval never holds a count beyond one bit
  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (int'(cnt_q) <= BIT_TICKS));
  // R9: disabling closes any open interval
  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !run_q);
endmodule

// File: rtl/jpp_spread_store.sv
module jpp_spread_store #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  input  logic [CW-1:0] done_val,
  output logic [CW-1:0] spread
);
  import jpp_pkg::*;

  logic          active_q, have_first_q;
  logic [CW-1:0] low_q, diff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      have_first_q <= 1'b0;
      low_q        <= '0;
      diff_q       <= '0;
    end else if (start) begin
      active_q     <= 1'b1;
      have_first_q <= 1'b0;
      low_q        <= '0;
      diff_q       <= '0;
    end else if (done && active_q) begin
      if (!have_first_q) begin
        low_q        <= done_val;
        diff_q       <= '0;
        have_first_q <= 1'b1;
      end else if (is_below(int'(done_val), int'(low_q))) begin
        low_q <= done_val;
      end else if (above_window(int'(done_val), int'(low_q), int'(diff_q))) begin
        diff_q <= CW'(new_spread(int'(done_val), int'(low_q)));
      end
    end
  end

  assign spread = diff_q;

  // R3: a start pulse clears the result
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (diff_q == '0));
  // R4: within a test the floor only moves down
  a_r4_floor_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && have_first_q && !start) |=> (low_q <= $past(low_q)));
  // R5: within a test the spread only grows
  a_r5_spread_up: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start) |=> (diff_q >= $past(diff_q)));
  // R13: nothing is stored before a test is armed
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start) |=> (diff_q == '0));
endmodule

// File: rtl/jpp_sample_hold.sv
module jpp_sample_hold #(
  parameter int CW   = 7,
  parameter int STEP = 10,
  parameter int LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [CW-1:0] done_val,
  output logic [CW-1:0] last_count,
  output logic [LW-1:0] level
);
  import jpp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_count <= '0;
      level      <= '0;
    end else if (done) begin
      last_count <= done_val;
      level      <= LW'(level_of(int'(done_val), STEP));
    end
  end

  // R2: a completed interval is presented one cycle later
  a_r2_present: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (last_count == $past(done_val)));
  // R9/R2: without a completion the held count does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(last_count));
endmodule

// File: rtl/jitter_pp_meter.sv
module jitter_pp_meter #(
  parameter int CNT_MAX   = 127,
  parameter int BIT_TICKS = 100,
  parameter int STEP      = 10,
  localparam int CW = $clog2(CNT_MAX + 1),
  localparam int LW = $clog2(CNT_MAX / STEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_in,
  input  logic          bit_stb,
  input  logic          tick,
  input  logic          mode_both,
  input  logic          ext_clk_sel,
  input  logic          start,
  output logic [CW-1:0] spread,
  output logic [CW-1:0] last_count,
  output logic [LW-1:0] level
);
  logic          meas_en;
  logic          qual_edge;
  logic          ivl_done;
  logic [CW-1:0] ivl_val;
  logic          ivl_running;

  assign meas_en = ~ext_clk_sel;

  jpp_edge_qual u_edge (
    .clk(clk), .rst_n(rst_n), .enable(meas_en), .data_in(data_in),
    .both_edges(mode_both), .qual(qual_edge)
  );

  jpp_interval_timer #(.CNT_MAX(CNT_MAX), .BIT_TICKS(BIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(meas_en), .qual(qual_edge),
    .bit_stb(bit_stb), .tick(tick), .done(ivl_done), .done_val(ivl_val),
    .running(ivl_running)
  );

  jpp_spread_store #(.CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .start(start), .done(ivl_done),
    .done_val(ivl_val), .spread(spread)
  );

  jpp_sample_hold #(.CW(CW), .STEP(STEP), .LW(LW)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(ivl_done), .done_val(ivl_val),
    .last_count(last_count), .level(level)
  );

  // R9: with the external clock selected no interval completes
  a_r9_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> !ivl_done);
  // R12: a qualifying edge always leaves an interval open
  a_r12_edge_opens: assert property (@(posedge clk) disable iff (!rst_n)
    qual_edge |=> ivl_running);
endmodule

// File: tb/jitter_pp_meter_test.sv
module jitter_pp_meter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0, bit_stb = 1'b0, tick = 1'b0;
  logic mode_both = 1'b0, ext_clk_sel = 1'b0, start = 1'b0;
  logic [6:0] spread, last_count;
  logic [3:0] level;

  always #(CLK_PERIOD/2) clk = ~clk;

  jitter_pp_meter uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .bit_stb(bit_stb),
    .tick(tick), .mode_both(mode_both), .ext_clk_sel(ext_clk_sel),
    .start(start), .spread(spread), .last_count(last_count), .level(level)
  );

  typedef struct {
    int    cnt;
    int    spr;
    int    lvl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  bit driver_done = 1'b0;

  // Independent reference state
  int  m_last = 0, m_low = 0, m_diff = 0;
  bit  m_armed = 1'b0, m_first = 1'b0;

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic void model_take(int c);
    m_last = c;
    if (!m_armed) return;
    if (!m_first) begin
      m_low = c; m_diff = 0; m_first = 1'b1;
    end else if (c < m_low) begin
      m_low = c;
    end else if (c - m_low > m_diff) begin
      m_diff = c - m_low;
    end
  endfunction

  // One cycle of stimulus, applied at a falling edge
  task automatic cyc(bit d, bit t, bit s);
    data_in = d; tick = t; bit_stb = s;
    @(negedge clk);
  endtask

  // Edge cycle at level lvl, n ticks, then a strobe; push expectation
  task automatic interval(int n, bit lvl, bit completes, string tag);
    exp_t e;
    cyc(lvl, 1'b0, 1'b0);
    repeat (n) cyc(lvl, 1'b1, 1'b0);
    cyc(lvl, 1'b0, 1'b1);
    if (completes) model_take(n);
    e.cnt = m_last; e.spr = m_diff; e.lvl = m_last / 10; e.tag = tag;
    exp_q.push_back(e);
    cyc(lvl, 1'b0, 1'b0);
  endtask

  task automatic rise_interval(int n, string tag);
    cyc(1'b0, 1'b0, 1'b0);
    interval(n, 1'b1, 1'b1, tag);
  endtask

  task automatic start_test();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_armed = 1'b1; m_first = 1'b0; m_low = 0; m_diff = 0;
  endtask

  // Monitor: compares outputs a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " last_count"}, int'(last_count), e.cnt);
        check({e.tag, " spread"}, int'(spread), e.spr);
        check({e.tag, " level (R11)"}, int'(level), e.lvl);
      end
    end
  end

  // Driver
  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 spread", int'(spread), 0);
    check("R1 last_count", int'(last_count), 0);
    check("R1 level", int'(level), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: before a test only the held count moves
    rise_interval(30, "R13 R2 pre-start");

    start_test();
    rise_interval(50, "R3 first loads floor");
    rise_interval(60, "R5 widen");
    rise_interval(55, "R6 inside window");
    rise_interval(40, "R4 new floor");
    rise_interval(48, "R6 inside shifted window");
    rise_interval(52, "R5 widen past shifted window");

    // R7: data is high now; a falling edge must not open an interval
    interval(20, 1'b0, 1'b0, "R7 falling ignored");

    // R12: restart on a second rising edge while open
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    repeat (30) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    interval(20, 1'b1, 1'b1, "R12 restart");

    // R10: 101 ticks is dropped, 100 ticks is kept
    cyc(1'b0, 1'b0, 1'b0);
    interval(101, 1'b1, 1'b0, "R10 timeout dropped");
    rise_interval(100, "R10 full bit kept");

    // R9: external clock selected
    ext_clk_sel = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    interval(20, 1'b1, 1'b0, "R9 disabled");
    ext_clk_sel = 1'b0;
    cyc(1'b1, 1'b0, 1'b0);

    // R8: both edges in total-peak mode
    mode_both = 1'b1;
    start_test();
    interval(30, 1'b0, 1'b1, "R8 falling counts");
    interval(70, 1'b1, 1'b1, "R8 rising counts");
    interval(35, 1'b0, 1'b1, "R8 R6 inside");
    interval(0,  1'b1, 1'b1, "R2 R4 zero count");
    interval(45, 1'b0, 1'b1, "R5 widen from zero floor");

    repeat (4) @(negedge clk);
    driver_done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (driver_done && exp_q.size() == 0);
        @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule